// File: doc/BRIEF.md
# Nibble-Wide Host Register Port

This block lets a host processor reach two 8-bit registers over a 4-bit data bus. A register-select input picks either the command register or the data register. A host strobe frames each 4-bit transfer, and the block acts on the falling edge of that strobe. An 8-bit write is made of two nibble writes. The block holds the first nibble and writes the whole byte into the selected register when the second nibble arrives. A read works the other way: the selected byte is split, and one nibble is returned on each strobe.

The high half of a byte always goes first. A one-bit phase tracks whether the next strobe carries the high half or the low half. Every strobe falling edge toggles this phase, for reads and writes alike.

Each write into a register starts a busy interval of a fixed number of clock cycles. The host can watch this interval through a status read. A host that does not poll must simply wait long enough between bytes. The busy flag only gates the low nibble, which is the one that writes the register. A byte whose low nibble arrives while busy is high is thrown away.

Top module: `nib_host_if`

## Requirements
- R1: After reset, the phase is high-half, busy is 0, both registers read 0 and bus_oe is 0.
- R2: The phase starts at high-half (0). It toggles on every falling edge of `strobe`, whether the access is a read or a write.
- R3: A write in phase 0 stores bus bits as byte bits 7..4. The following write in phase 1 supplies bits 3..0. On that second falling edge, the byte goes to the command register if `rsel`=0 and to the data register if `rsel`=1.
- R4: When a byte is written, `busy` rises on the next clock. It then stays high for exactly BUSY_CYC cycles (default 10).
- R5: A low-nibble write that arrives while `busy` is 1 is dropped. The target register keeps its old value, and the busy interval is not restarted.
- R6: A read with `rsel`=0 returns, in phase 0, bit 3 = `busy` and bits 2..0 = `stat_in[6:4]`. In phase 1 it returns `stat_in[3:0]`.
- R7: A read with `rsel`=1 returns data-register bits 7..4 in phase 0 and bits 3..0 in phase 1.
- R8: `bus_oe` is 1 exactly when `strobe` and `rd_nwr` are both 1. Reads never change either register.
- R9: A high-nibble write is captured even while `busy` is 1. Only the low nibble is gated by busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Transfer strobe; the block acts on its falling edge |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| rsel | input | 1 | 0 = command register / status, 1 = data register |
| bus_in | input | 4 | Nibble driven by the host |
| bus_out | output | 4 | Nibble driven to the host |
| bus_oe | output | 1 | Enable for the bus driver |
| stat_in | input | 7 | Status/address value returned by status reads |
| cmd_q | output | 8 | Command register |
| dat_q | output | 8 | Data register |
| busy | output | 1 | Busy interval active |

## Verification
A random sequence writes bytes to both registers and then reads them back, with random status values. A mismatch there points to nibble order or register steering going wrong.

Directed back-to-back writes land their low nibble inside the busy interval. These show whether the drop works and whether the interval end stays fixed. A high nibble written during busy, followed by a late low nibble, separates a gate placed on the high nibble from one placed on the low nibble.

Counting busy cycles after each write pins down the interval length. Odd-length strobe sequences reveal a phase that fails to toggle on reads.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  // phase 0 carries bits 7..4, phase 1 carries bits 3..0
  function automatic logic [NIB_W-1:0] byte_part(input logic [BYTE_W-1:0] b,
                                                 input logic ph);
    return ph ? b[NIB_W-1:0] : b[BYTE_W-1:NIB_W];
  endfunction

  function automatic logic [BYTE_W-1:0] byte_join(input logic [NIB_W-1:0] hi,
                                                  input logic [NIB_W-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/nib_strobe_seq.sv
module nib_strobe_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall,
  output logic phase
);
  logic strobe_d;

  assign fall = strobe_d & ~strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      phase    <= 1'b0;
    end else begin
      strobe_d <= strobe;
      if (fall) phase <= ~phase;
    end
  end
endmodule

// File: rtl/nib_busy_timer.sv
module nib_busy_timer #(
  parameter int BUSY_CYC = 10,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= CNT_W'(BUSY_CYC);
    else if (busy)  cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/nib_byte_pack.sv
module nib_byte_pack
  import nib_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              phase,
  input  logic              rd_nwr,
  input  logic              rsel,
  input  logic              busy,
  input  logic [NIB_W-1:0]  din,
  output logic              cmd_commit,
  output logic              dat_commit,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] dat_q
);
  logic [NIB_W-1:0] hold;
  logic             wr_hi, wr_lo;

  assign wr_hi      = fall & ~rd_nwr & ~phase;
  assign wr_lo      = fall & ~rd_nwr &  phase;
  assign cmd_commit = wr_lo & ~busy & ~rsel;
  assign dat_commit = wr_lo & ~busy &  rsel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      cmd_q <= '0;
      dat_q <= '0;
    end else begin
      if (wr_hi)      hold  <= din;
      if (cmd_commit) cmd_q <= byte_join(hold, din);
      if (dat_commit) dat_q <= byte_join(hold, din);
    end
  end
endmodule

// File: rtl/nib_host_if.sv
module nib_host_if
  import nib_pkg::*;
#(
  parameter int BUSY_CYC = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              rd_nwr,
  input  logic              rsel,
  input  logic [NIB_W-1:0]  bus_in,
  output logic [NIB_W-1:0]  bus_out,
  output logic              bus_oe,
  input  logic [BYTE_W-2:0] stat_in,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] dat_q,
  output logic              busy
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic             fall, phase;
  logic             cmd_commit, dat_commit;
  logic [CNT_W-1:0] busy_cnt;
  logic [BYTE_W-1:0] rd_byte;

  nib_strobe_seq u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fall(fall), .phase(phase)
  );

  nib_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(cmd_commit | dat_commit),
    .busy(busy), .cnt(busy_cnt)
  );

  nib_byte_pack u_pack (
    .clk(clk), .rst_n(rst_n), .fall(fall), .phase(phase), .rd_nwr(rd_nwr),
    .rsel(rsel), .busy(busy), .din(bus_in), .cmd_commit(cmd_commit),
    .dat_commit(dat_commit), .cmd_q(cmd_q), .dat_q(dat_q)
  );

  assign rd_byte = rsel ? dat_q : {busy, stat_in};
  assign bus_out = byte_part(rd_byte, phase);
  assign bus_oe  = strobe & rd_nwr;
endmodule

// File: rtl/nib_host_if_chk.sv
module nib_host_if_chk #(
  parameter int BUSY_CYC = 10,
  localparam int CNT_W = $clog2(BUSY_CYC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe,
  input logic             rd_nwr,
  input logic             rsel,
  input logic             fall,
  input logic             phase,
  input logic             busy,
  input logic [CNT_W-1:0] busy_cnt,
  input logic             cmd_commit,
  input logic             dat_commit,
  input logic             bus_oe,
  input logic [3:0]       bus_out,
  input logic [7:0]       cmd_q,
  input logic [7:0]       dat_q
);
  // R2
  phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> phase != $past(phase));
  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(phase));
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_commit || dat_commit) |=> busy && busy_cnt == CNT_W'(BUSY_CYC));
  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(cmd_commit || dat_commit));
  // R3
  cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_commit |=> $stable(cmd_q));
  // R3
  dat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_commit |=> $stable(dat_q));
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe == (strobe && rd_nwr));
  // R6
  busy_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsel && !phase) |-> bus_out[3] == busy);
endmodule

bind nib_host_if nib_host_if_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr), .rsel(rsel),
  .fall(fall), .phase(phase), .busy(busy), .busy_cnt(busy_cnt),
  .cmd_commit(cmd_commit), .dat_commit(dat_commit), .bus_oe(bus_oe),
  .bus_out(bus_out), .cmd_q(cmd_q), .dat_q(dat_q)
);

// File: tb/test_nib_host_if.sv
`timescale 1ns/1ps
module test_nib_host_if;
  localparam int BUSY_CYC = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       strobe = 1'b0, rd_nwr = 1'b0, rsel = 1'b0;
  logic [3:0] bus_in = '0;
  logic [6:0] stat_in = '0;
  logic [3:0] bus_out;
  logic       bus_oe, busy;
  logic [7:0] cmd_q, dat_q;

  int n_chk = 0, n_bad = 0, ncyc = 0;
  logic [3:0] rd_nib;
  logic       oe_seen;

  always #2.5 clk = ~clk;
  always @(posedge clk) ncyc++;

  nib_host_if #(.BUSY_CYC(BUSY_CYC)) i_nib_host_if (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd_nwr(rd_nwr), .rsel(rsel),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .stat_in(stat_in),
    .cmd_q(cmd_q), .dat_q(dat_q), .busy(busy)
  );

  function automatic logic [3:0] exp_part(input logic [7:0] b, input bit lo);
    return lo ? b & 8'h0F : b >> 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one strobe pulse; returns just after the clock edge that sees the fall
  task automatic nib(input bit rw, input bit rs, input logic [3:0] d);
    @(negedge clk);
    rd_nwr = rw; rsel = rs; bus_in = d; strobe = 1'b1;
    #1;
    rd_nib  = bus_out;
    oe_seen = bus_oe;
    @(negedge clk);
    strobe = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic wr_byte(input bit rs, input logic [7:0] b);
    nib(1'b0, rs, b[7:4]);
    nib(1'b0, rs, b[3:0]);
  endtask

  task automatic rd_byte(input bit rs, output logic [7:0] b);
    nib(1'b1, rs, 4'h0); b[7:4] = rd_nib;
    nib(1'b1, rs, 4'h0); b[3:0] = rd_nib;
  endtask

  // cycles from t0 until busy is seen low
  task automatic busy_span(input int t0, output int span);
    while (1) begin
      @(negedge clk);
      if (!busy) break;
    end
    span = ncyc - t0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, span;
    logic [7:0] r, old_dat, old_cmd;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check("R1 busy", busy, 0);
    check("R1 cmd", cmd_q, 0);
    check("R1 dat", dat_q, 0);
    check("R1 oe", bus_oe, 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R7: first read after reset is high half
    rd_byte(1'b1, r);
    check("R7 reset read", r, 0);
    check("R8 oe on read", oe_seen, 1);

    // R3/R4 directed
    wr_byte(1'b1, 8'hA5); t0 = ncyc;
    check("R3 dat write", dat_q, 8'hA5);
    check("R8 oe on write", oe_seen, 0);
    busy_span(t0, span);
    check("R4 busy length", span, BUSY_CYC);
    wr_byte(1'b0, 8'h3C); t0 = ncyc;
    check("R3 cmd write", cmd_q, 8'h3C);
    check("R3 dat untouched", dat_q, 8'hA5);
    busy_span(t0, span);

    // R5: back-to-back byte dropped, interval not restarted
    wr_byte(1'b1, 8'h11); t0 = ncyc;
    wr_byte(1'b1, 8'h77);
    check("R5 dropped byte", dat_q, 8'h11);
    busy_span(t0, span);
    check("R5 busy not restarted", span, BUSY_CYC);

    // R9: high nibble during busy, low nibble after
    wr_byte(1'b0, 8'h42);
    nib(1'b0, 1'b0, 4'h9);
    repeat (BUSY_CYC + 2) @(posedge clk);
    #1;
    nib(1'b0, 1'b0, 4'h6);
    check("R9 high nibble while busy", cmd_q, 8'h96);
    busy_span(ncyc, span);

    // R2: single read strobe moves phase; next read gets low half
    stat_in = 7'h5B;
    nib(1'b1, 1'b1, 4'h0);
    check("R2 odd phase", rd_nib, exp_part(dat_q, 1'b0));
    nib(1'b1, 1'b1, 4'h0);
    check("R2 phase low", rd_nib, exp_part(dat_q, 1'b1));

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit rs;
      logic [7:0] b, st;
      rs = 1'($urandom);
      b  = 8'($urandom);
      stat_in = 7'($urandom);
      old_dat = dat_q; old_cmd = cmd_q;
      wr_byte(rs, b);
      check("R3 random target", rs ? dat_q : cmd_q, b);
      check("R3 random other", rs ? cmd_q : dat_q, rs ? old_cmd : old_dat);
      rd_byte(1'b0, st);
      check("R6 status busy", st, {1'b1, stat_in});
      while (busy) @(negedge clk);
      rd_byte(1'b0, st);
      check("R6 status idle", st, {1'b0, stat_in});
      old_cmd = cmd_q;
      rd_byte(1'b1, r);
      check("R7 data read", r, dat_q);
      check("R8 read no effect", cmd_q, old_cmd);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule